// File: doc/BRIEF.md
# GPIO controller with pin interrupts

This block is a general-purpose I/O peripheral driven through a flat word-addressed register interface (address, write strobe, write data, combinational read data). Every pin has a direction bit, a bit that hands the pin over to an alternate function, and a bit of output data. Every pin level is brought through a two-flop synchroniser and can be read back at any time. Pins are split into a low bank (pins 0 to 31) and a high bank (pins 32 and up). In the high bank, register bit k stands for pin 32+k.

The lowest IRQ_PINS pins each have an interrupt detector. Three independent configuration bits per pin (edge-mode, high, low) choose level-low, level-high, rising, falling or both-edge detection, or no detection. Detected requests land in a pending register. A pending bit is released by holding its bit in a level-sensitive clear register at 1. Software writes 1s and then 0s. A per-pin enable register gates pending bits into a single combined request line.

Top module: `gpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every writable register and every pending bit is 0, so all pin output enables and the interrupt request are 0.
- R2: Word addresses: 0 dir-low, 1 dir-high, 2 sel-low, 3 sel-high, 4 out-low, 5 out-high, 6 in-low, 7 in-high, 8 trig-edge, 9 trig-high, 10 trig-low, 11 irq-enable, 12 irq-clear, 13 pending. Low-bank bit i is pin i and high-bank bit k is pin 32+k. High-bank bits with no pin read 0. Unused addresses read 0. Writes to addresses 6, 7, 13 and unused addresses change nothing.
- R3: With the select bit at 0, a pin's output enable equals its direction bit (1 = drive) and its output value equals its output-data bit.
- R4: With the select bit at 1, a pin's output enable and output value come from the alternate-function inputs for that pin.
- R5: The input registers return each pin's level as sampled two clock edges earlier, whatever its direction or select bit.
- R6: With edge-mode 0, a pending bit follows its condition: (high AND level) OR (low AND NOT level), using the synchronised level. It updates one edge after the synchronised value changes, so it drops when the level goes away.
- R7: With edge-mode 1, a rising synchronised edge with high=1, or a falling one with low=1, sets the pending bit. The bit then stays set until cleared.
- R8: While a pin's clear bit is 1, its pending bit is 0 and edges arriving in that time are lost. Once the clear bit returns to 0, detection resumes.
- R9: The interrupt request is the OR over pins of (pending AND enable). The pending register reads back regardless of enable.
- R10: The interrupt configuration, enable, clear and pending registers are IRQ_PINS bits wide and higher bits read 0. A pin with all three configuration bits at 0 never pends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| alt_out | input | NUM_PINS | Alternate-function output value |
| alt_oe | input | NUM_PINS | Alternate-function output enable |
| pin_out | output | NUM_PINS | Output value to the pads |
| pin_oe | output | NUM_PINS | Output enable to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PINS = 40 and IRQ_PINS = 16. This leaves the high bank only partly populated, so the zero read-back of missing pins is visible on bits 8 to 31 of the high registers. The narrower interrupt field can be shown to drop bits 16 to 31, and pins 16 to 39 can be toggled to show that they never raise a request. With 16 detector pins, random configuration, enable and clear writes mixed with random pin toggles hit every detection mode in a few hundred cycles.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO controller: register word addresses,
// bank width, and the per-pin interrupt trigger configuration.
package gpio_pkg;

    localparam int BANK_W = 32;

    typedef enum logic [3:0] {
        A_DIR_LO   = 4'd0,
        A_DIR_HI   = 4'd1,
        A_SEL_LO   = 4'd2,
        A_SEL_HI   = 4'd3,
        A_OUT_LO   = 4'd4,
        A_OUT_HI   = 4'd5,
        A_IN_LO    = 4'd6,
        A_IN_HI    = 4'd7,
        A_TRG_EDGE = 4'd8,
        A_TRG_HIGH = 4'd9,
        A_TRG_LOW  = 4'd10,
        A_IRQ_EN   = 4'd11,
        A_IRQ_CLR  = 4'd12,
        A_PEND     = 4'd13
    } gpio_reg_e;

    typedef struct packed {
        logic is_edge;
        logic on_high;
        logic on_low;
    } trig_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for the pin inputs.
// Assumes: pin levels are asynchronous to clk; the output lags by two edges.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage resampling of the raw pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_irq_cell.sv
// Interrupt detector for one pin: level or edge detection and a pending flag
// that is held low while the clear bit is set.
// Assumes: level is already synchronised to clk.
module gpio_irq_cell
    import gpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      pend
);
    logic prev_q;
    logic rise, fall, evt, lvl_hit, pend_d;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Next value of the pending flag from the mode, the condition and the clear.
    always_comb begin
        rise    = level & ~prev_q;
        fall    = ~level & prev_q;
        evt     = (cfg.on_high & rise) | (cfg.on_low & fall);
        lvl_hit = (cfg.on_high & level) | (cfg.on_low & ~level);
        if (clr)              pend_d = 1'b0;
        else if (cfg.is_edge) pend_d = pend | evt;
        else                  pend_d = lvl_hit;
    end

    // Pending flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= pend_d;
    end

    AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend); // R8
    AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.is_edge && cfg.on_high && !clr && level) |=> pend); // R6
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.is_edge && pend && !clr) |=> pend); // R7
    AST_OFF_NEVER_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.is_edge && !cfg.on_high && !cfg.on_low) |=> !pend); // R10
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin choice between GPIO registers and the alternate function for
// output value and output enable.
// Assumes: pure combinational; all vectors are one bit per pin.
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] sel,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] out_reg,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    // Bitwise steer of each pin to GPIO or alternate source.
    always_comb begin
        pin_oe  = (sel & alt_oe)  | (~sel & dir);
        pin_out = (sel & alt_out) | (~sel & out_reg);
    end
endmodule

// File: rtl/gpio_ctrl.sv
// GPIO controller top: register file over two pin banks, input synchroniser,
// output muxing and per-pin interrupt detectors merged into one request.
// Assumes: 33 <= NUM_PINS <= 64, 1 <= IRQ_PINS <= 32, IRQ_PINS <= NUM_PINS.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int IRQ_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          addr,
    input  logic                wr_en,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NP = NUM_PINS;
    localparam int IP = IRQ_PINS;

    logic [NP-1:0] dir_q, sel_q, out_q, sync_lvl;
    logic [IP-1:0] edge_q, high_q, low_q, en_q, clr_q, pend;

    // Write one bank of a per-pin register, keeping the other bank.
    function automatic logic [NP-1:0] bank_wr(input logic [NP-1:0] cur,
                                              input logic hi, input logic [31:0] d);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = ((i >= BANK_W) == hi) ? d[i % BANK_W] : cur[i];
        return r;
    endfunction

    // Read one bank of a per-pin register; missing pins read 0.
    function automatic logic [31:0] bank_rd(input logic [NP-1:0] v, input logic hi);
        logic [31:0] r;
        for (int j = 0; j < BANK_W; j++) begin
            int idx;
            idx  = hi ? j + BANK_W : j;
            r[j] = (idx < NP) ? v[idx] : 1'b0;
        end
        return r;
    endfunction

    // Zero-extend an interrupt-field register to the bus width.
    function automatic logic [31:0] field_rd(input logic [IP-1:0] v);
        logic [31:0] r;
        for (int j = 0; j < 32; j++)
            r[j] = (j < IP) ? v[j] : 1'b0;
        return r;
    endfunction

    // Register writes from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            sel_q  <= '0;
            out_q  <= '0;
            edge_q <= '0;
            high_q <= '0;
            low_q  <= '0;
            en_q   <= '0;
            clr_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                A_DIR_LO:   dir_q  <= bank_wr(dir_q, 1'b0, wdata);
                A_DIR_HI:   dir_q  <= bank_wr(dir_q, 1'b1, wdata);
                A_SEL_LO:   sel_q  <= bank_wr(sel_q, 1'b0, wdata);
                A_SEL_HI:   sel_q  <= bank_wr(sel_q, 1'b1, wdata);
                A_OUT_LO:   out_q  <= bank_wr(out_q, 1'b0, wdata);
                A_OUT_HI:   out_q  <= bank_wr(out_q, 1'b1, wdata);
                A_TRG_EDGE: edge_q <= wdata[IP-1:0];
                A_TRG_HIGH: high_q <= wdata[IP-1:0];
                A_TRG_LOW:  low_q  <= wdata[IP-1:0];
                A_IRQ_EN:   en_q   <= wdata[IP-1:0];
                A_IRQ_CLR:  clr_q  <= wdata[IP-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_DIR_LO:   rdata = bank_rd(dir_q, 1'b0);
            A_DIR_HI:   rdata = bank_rd(dir_q, 1'b1);
            A_SEL_LO:   rdata = bank_rd(sel_q, 1'b0);
            A_SEL_HI:   rdata = bank_rd(sel_q, 1'b1);
            A_OUT_LO:   rdata = bank_rd(out_q, 1'b0);
            A_OUT_HI:   rdata = bank_rd(out_q, 1'b1);
            A_IN_LO:    rdata = bank_rd(sync_lvl, 1'b0);
            A_IN_HI:    rdata = bank_rd(sync_lvl, 1'b1);
            A_TRG_EDGE: rdata = field_rd(edge_q);
            A_TRG_HIGH: rdata = field_rd(high_q);
            A_TRG_LOW:  rdata = field_rd(low_q);
            A_IRQ_EN:   rdata = field_rd(en_q);
            A_IRQ_CLR:  rdata = field_rd(clr_q);
            A_PEND:     rdata = field_rd(pend);
            default:    rdata = '0;
        endcase
    end

    gpio_sync #(.W(NP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    gpio_pin_mux #(.W(NP)) u_mux (
        .sel     (sel_q),
        .dir     (dir_q),
        .out_reg (out_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    for (genvar g = 0; g < IP; g++) begin : g_irq
        trig_cfg_t cfg;
        assign cfg = '{is_edge: edge_q[g], on_high: high_q[g], on_low: low_q[g]};
        gpio_irq_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .level (sync_lvl[g]),
            .cfg   (cfg),
            .clr   (clr_q[g]),
            .pend  (pend[g])
        );
    end

    // Combined request.
    assign irq = |(pend & en_q);

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR_LO && !sel_q[0]) |=> (pin_oe[0] == $past(wdata[0]))); // R3
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq); // R9
endmodule

// File: tb/sim_gpio_ctrl.sv
// Bench: directed corner cases, then random register writes and pin toggles,
// all checked against a cycle model built from the requirements.
module sim_gpio_ctrl;
    import gpio_pkg::*;

    localparam int NP = 40;
    localparam int IP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    // Model state.
    logic [NP-1:0] m_dir = '0, m_sel = '0, m_out = '0, m_s1 = '0, m_s2 = '0;
    logic [IP-1:0] m_te = '0, m_th = '0, m_tl = '0, m_en = '0, m_clr = '0;
    logic [IP-1:0] m_pend = '0, m_pv = '0;

    gpio_ctrl #(.NUM_PINS(NP), .IRQ_PINS(IP)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            A_DIR_LO:   return m_dir[31:0];
            A_DIR_HI:   return 32'(m_dir[NP-1:32]);
            A_SEL_LO:   return m_sel[31:0];
            A_SEL_HI:   return 32'(m_sel[NP-1:32]);
            A_OUT_LO:   return m_out[31:0];
            A_OUT_HI:   return 32'(m_out[NP-1:32]);
            A_IN_LO:    return m_s2[31:0];
            A_IN_HI:    return 32'(m_s2[NP-1:32]);
            A_TRG_EDGE: return 32'(m_te);
            A_TRG_HIGH: return 32'(m_th);
            A_TRG_LOW:  return 32'(m_tl);
            A_IRQ_EN:   return 32'(m_en);
            A_IRQ_CLR:  return 32'(m_clr);
            A_PEND:     return 32'(m_pend);
            default:    return 32'd0;
        endcase
    endfunction

    task automatic model_edge(input logic we, input logic [3:0] a, input logic [31:0] d,
                              input logic [NP-1:0] p);
        logic [IP-1:0] nx;
        for (int i = 0; i < IP; i++) begin
            logic r, f;
            r = m_s2[i] & ~m_pv[i];
            f = ~m_s2[i] & m_pv[i];
            if (m_clr[i])     nx[i] = 1'b0;
            else if (m_te[i]) nx[i] = m_pend[i] | (m_th[i] & r) | (m_tl[i] & f);
            else              nx[i] = (m_th[i] & m_s2[i]) | (m_tl[i] & ~m_s2[i]);
        end
        m_pend = nx;
        m_pv   = m_s2[IP-1:0];
        m_s2   = m_s1;
        m_s1   = p;
        if (we) begin
            case (a)
                A_DIR_LO:   m_dir[31:0]    = d;
                A_DIR_HI:   m_dir[NP-1:32] = d[NP-33:0];
                A_SEL_LO:   m_sel[31:0]    = d;
                A_SEL_HI:   m_sel[NP-1:32] = d[NP-33:0];
                A_OUT_LO:   m_out[31:0]    = d;
                A_OUT_HI:   m_out[NP-1:32] = d[NP-33:0];
                A_TRG_EDGE: m_te  = d[IP-1:0];
                A_TRG_HIGH: m_th  = d[IP-1:0];
                A_TRG_LOW:  m_tl  = d[IP-1:0];
                A_IRQ_EN:   m_en  = d[IP-1:0];
                A_IRQ_CLR:  m_clr = d[IP-1:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, model at posedge, compare shortly after.
    task automatic step(input string tag, input logic we, input logic [3:0] a,
                        input logic [31:0] d, input logic [NP-1:0] p,
                        input logic [NP-1:0] ao, input logic [NP-1:0] aoe);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; pin_in = p; alt_out = ao; alt_oe = aoe;
        @(posedge clk);
        model_edge(we, a, d, p);
        #1 wr_en = 1'b0;
        #1;
        check(tag, "rdata", 64'(rdata), 64'(model_read(a)));
        check(tag, "irq", 64'(irq), 64'(|(m_pend & m_en)));
        check(tag, "pin_oe", 64'(pin_oe), 64'((m_sel & alt_oe) | (~m_sel & m_dir)));
        check(tag, "pin_out", 64'(pin_out), 64'((m_sel & alt_out) | (~m_sel & m_out)));
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [31:0] d);
        step(tag, 1'b1, a, d, pin_in, alt_out, alt_oe);
    endtask

    task automatic rd(input string tag, input logic [3:0] a);
        step(tag, 1'b0, a, 32'd0, pin_in, alt_out, alt_oe);
    endtask

    task automatic pin(input string tag, input logic [NP-1:0] p, input logic [3:0] a);
        step(tag, 1'b0, a, 32'd0, p, alt_out, alt_oe);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every register and the outputs
        for (int a = 0; a < 16; a++) rd("R1", 4'(a));

        // R2: high bank holds only 8 pins; unused and read-only addresses ignore writes
        wr("R2", A_DIR_HI, 32'hFFFF_FFFF);
        rd("R2", A_DIR_HI);
        wr("R2", A_IN_LO, 32'hFFFF_FFFF);
        wr("R2", 4'd14, 32'hFFFF_FFFF);
        rd("R2", A_IN_LO);
        rd("R2", 4'd15);
        wr("R2", A_DIR_HI, 32'h0);

        // R3: GPIO mode, direction and data
        wr("R3", A_OUT_LO, 32'h5A5A_C3C3);
        wr("R3", A_DIR_LO, 32'hF0F0_0FF1);
        wr("R3", A_OUT_HI, 32'h0000_00A5);
        wr("R3", A_DIR_HI, 32'h0000_003C);

        // R4: alternate function owns the selected pins
        step("R4", 1'b1, A_SEL_LO, 32'hFFFF_0000, pin_in, 40'hA5_1234_5678, 40'h3C_0F0F_F0F0);
        wr("R4", A_SEL_HI, 32'h0000_000F);
        rd("R4", A_SEL_LO);
        wr("R4", A_SEL_LO, 32'h0);
        wr("R4", A_SEL_HI, 32'h0);

        // R5: inputs seen two edges later, any direction
        for (int k = 0; k < 6; k++)
            pin("R5", {$urandom, $urandom}, (k % 2 == 0) ? A_IN_LO : A_IN_HI);
        pin("R5", '0, A_IN_LO);
        pin("R5", '0, A_IN_LO);
        pin("R5", '0, A_IN_HI);

        // R10: interrupt field is 16 bits; pins above it never pend
        wr("R10", A_TRG_EDGE, 32'hFFFF_FFFF);
        rd("R10", A_TRG_EDGE);
        wr("R10", A_TRG_EDGE, 32'h0);
        wr("R10", A_IRQ_EN, 32'hFFFF_FFFF);
        for (int k = 0; k < 5; k++) pin("R10", 40'hFF_FFFF_0000, A_PEND);
        pin("R10", '0, A_PEND);

        // R6: level-high on pin 1, level-low on pin 2
        wr("R6", A_TRG_HIGH, 32'h0000_0002);
        wr("R6", A_TRG_LOW, 32'h0000_0004);
        for (int k = 0; k < 4; k++) pin("R6", 40'h2, A_PEND);
        for (int k = 0; k < 4; k++) pin("R6", 40'h4, A_PEND);
        wr("R6", A_TRG_LOW, 32'h0);
        wr("R6", A_TRG_HIGH, 32'h0);

        // R7: rising on pin 5, falling on pin 6, both on pin 7
        wr("R7", A_TRG_EDGE, 32'h0000_00E0);
        wr("R7", A_TRG_HIGH, 32'h0000_00A0);
        wr("R7", A_TRG_LOW, 32'h0000_00C0);
        for (int k = 0; k < 4; k++) pin("R7", 40'hE0, A_PEND);
        for (int k = 0; k < 4; k++) pin("R7", 40'h00, A_PEND);

        // R8: clear held while a new edge arrives, then released
        wr("R8", A_IRQ_CLR, 32'h0000_00E0);
        for (int k = 0; k < 4; k++) pin("R8", 40'hE0, A_PEND);
        wr("R8", A_IRQ_CLR, 32'h0);
        for (int k = 0; k < 3; k++) rd("R8", A_PEND);
        for (int k = 0; k < 4; k++) pin("R8", 40'h00, A_PEND);

        // R9: pending visible but request masked by enable
        wr("R9", A_IRQ_EN, 32'h0);
        rd("R9", A_PEND);
        wr("R9", A_IRQ_EN, 32'h0000_0040);
        rd("R9", A_PEND);
        wr("R9", A_IRQ_CLR, 32'hFFFF);
        wr("R9", A_IRQ_CLR, 32'h0);

        // Mixed random traffic: registers, pins, alternate inputs.
        for (int n = 0; n < 1500; n++) begin
            logic [3:0]    a;
            logic [31:0]   d;
            logic [NP-1:0] p;
            logic          we;
            a  = 4'($urandom_range(0, 15));
            d  = $urandom;
            we = ($urandom_range(0, 3) == 0);
            if (a == A_IRQ_CLR && $urandom_range(0, 3) != 0) d = 32'h0;
            p = pin_in;
            if ($urandom_range(0, 1) == 0) p[$urandom_range(0, NP - 1)] ^= 1'b1;
            if ($urandom_range(0, 7) == 0) p = {$urandom, $urandom};
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10", we, a, d, p, {$urandom, $urandom},
                 {$urandom, $urandom});
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule